// File: doc/BRIEF.md
# SAR Conversion Sequencer

This block is the digital half of a successive-approximation analog-to-digital converter. It derives a conversion clock from the system clock and controls one channel conversion at a time. During a conversion it drives a trial code to the external DAC and reads back a single comparator bit. Each conversion has a sampling phase followed by one trial per result bit, most significant bit first. The finished code goes into a per-channel result store that software reads one byte at a time.

Software starts a run by pulsing a start request while the reference-connect input is high. The resolution, sample-and-hold choice, clock divider, scan mode and channel are captured at that moment. Three scan modes are supported: a single conversion, repeated conversion of one channel, and one ordered sweep over a range of channels. Each finished conversion also raises a one-cycle result strobe carrying the channel and the code. The strobe has no ready input, because the comparator cannot be stalled mid-search. A consumer must accept every strobe in the cycle it appears.

Top module: `sar_conv_seq`

## Requirements
- R1: The conversion clock ticks once every 1, 2 or 4 system clocks for `div_sel` values 0, 1 and 2. The value 3 also selects 4.
- R2: `busy` stays high for exactly L ticks per channel. L is 49 (8-bit, no sample-and-hold), 59 (10-bit, no sample-and-hold), 28 (8-bit, sample-and-hold) or 33 (10-bit, sample-and-hold).
- R3: The first L−T ticks are a sampling phase, where T is 10 or 8 trials. Then T trials follow, one per tick, starting from bit 9 of `dac_code` and moving down. Each trial keeps its bit if `cmp_in` is 1. `dac_code` is 0 whenever no trial is active. When `cmp_in` means "input ≥ `dac_code`", the 10-bit result equals the input.
- R4: In 8-bit mode the trials use `dac_code` bits 9 down to 2 only, and the result is those 8 bits. Only the channel's even byte is written; its odd byte keeps its old value.
- R5: Byte address 2·ch reads bits 7:0 of channel ch's result, and address 2·ch+1 reads {6'b0, bits 9:8}. Addresses for channels 13 and up read 0. After reset every byte reads 0.
- R6: `start_set` takes effect only when `ref_on` is 1, no run is active, and `chan_sel` is below 13. Otherwise it is ignored.
- R7: In single mode (`mode_sel` 0 or 3), exactly one conversion happens and `start_flag` clears when it ends.
- R8: In repeat mode (`mode_sel` 1), the channel is converted back to back while `start_flag` is set. `start_clr` lets the running conversion finish and then stops.
- R9: In sweep mode (`mode_sel` 2), channels 0 up to `chan_sel` are converted once each in ascending order. Then `start_flag` clears.
- R10: `res_valid` pulses for one cycle, one clock after each conversion's last tick, carrying `res_chan` and `res_data`. In 8-bit mode the 8-bit result sits in the low bits and the upper bits are 0.
- R11: The configuration inputs are captured when a start is accepted. Changing them during a run has no effect on that run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_on | input | 1 | Reference ladder connected; required for a start |
| start_set | input | 1 | Software start request (one-cycle pulse) |
| start_clr | input | 1 | Software clear of the start flag |
| res10_sel | input | 1 | 1 = 10-bit, 0 = 8-bit resolution |
| sh_en | input | 1 | Sample-and-hold timing enable |
| div_sel | input | 2 | Conversion clock divider select |
| mode_sel | input | 2 | 0 single, 1 repeat, 2 sweep, 3 single |
| chan_sel | input | 4 | Channel (single/repeat) or last channel (sweep) |
| cmp_in | input | 1 | Comparator result for the current trial code |
| dac_code | output | 10 | Trial code to the DAC |
| conv_chan | output | 4 | Channel currently being converted |
| busy | output | 1 | Conversion in progress |
| start_flag | output | 1 | Start flag state |
| res_valid | output | 1 | Result strobe |
| res_chan | output | 4 | Channel of the strobed result |
| res_data | output | 10 | Strobed result code |
| rd_addr | input | 5 | Result byte address |
| rd_data | output | 8 | Result byte read data |

## Verification
The bench uses the default parameters: 13 channels, a 10-bit code, and the 49/59/28/33 tick lengths. This lets it measure the full-length `busy` windows at every divider setting and count the sampling cycles before the first trial. Because 13 is not a power of two, addresses 26 to 31 are unmapped, so the zero-read rule for them can be tested directly. A digital comparator model lets each expected code be computed from the modelled input value alone.

// File: rtl/sar_pkg.sv
package sar_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    SCAN_SINGLE = 2'd0,
    SCAN_REPEAT = 2'd1,
    SCAN_SWEEP  = 2'd2,
    SCAN_ALT    = 2'd3
  } scan_mode_e;

  typedef struct packed {
    logic       res10;
    logic       sh;
    logic [1:0] div;
    scan_mode_e mode;
  } run_cfg_t;

endpackage

// File: rtl/sar_prescale.sv
module sar_prescale (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       restart,
  input  logic       active,
  input  logic [1:0] div_sel,
  output logic       tick
);
  localparam int PW = 2;

  logic [PW-1:0] phase_q;
  logic [PW-1:0] limit;

  always_comb begin
    unique case (div_sel)
      2'd0:    limit = '0;
      2'd1:    limit = PW'(1);
      default: limit = PW'(3);
    endcase
  end

  assign tick = active && (phase_q == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       phase_q <= '0;
    else if (restart) phase_q <= '0;
    else if (active)  phase_q <= tick ? '0 : phase_q + PW'(1);
    else              phase_q <= '0;
  end
endmodule

// File: rtl/sar_ctrl.sv
module sar_ctrl
  import sar_pkg::*;
#(
  parameter int NUM_CH       = 13,
  parameter int RES_W        = 10,
  parameter int LEN_PLAIN_LO = 49,
  parameter int LEN_PLAIN_HI = 59,
  parameter int LEN_SH_LO    = 28,
  parameter int LEN_SH_HI    = 33,
  parameter int CH_W         = 4,
  parameter int CNT_W        = 6,
  parameter int BIT_W        = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_on,
  input  logic             start_set,
  input  logic             start_clr,
  input  logic             res10_in,
  input  logic             sh_in,
  input  logic [1:0]       div_in,
  input  logic [1:0]       mode_in,
  input  logic [CH_W-1:0]  chan_in,
  input  logic             tick,
  output logic             go,
  output logic             active,
  output logic             run,
  output logic             cfg_res10,
  output logic [1:0]       cfg_div,
  output logic [1:0]       cfg_mode,
  output logic [CH_W-1:0]  cur_chan,
  output logic             in_trial,
  output logic [BIT_W-1:0] bit_idx,
  output logic             acc_clear,
  output logic             commit
);
  run_cfg_t        cfg_q;
  logic [CH_W-1:0] last_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] len, trials, samp;
  logic             chan_ok, cont;

  assign chan_ok = ({1'b0, chan_in} < (CH_W+1)'(NUM_CH));
  assign go      = start_set && ref_on && !run && !active && chan_ok;

  always_comb begin
    unique case ({cfg_q.sh, cfg_q.res10})
      2'b00:   len = CNT_W'(LEN_PLAIN_LO);
      2'b01:   len = CNT_W'(LEN_PLAIN_HI);
      2'b10:   len = CNT_W'(LEN_SH_LO);
      default: len = CNT_W'(LEN_SH_HI);
    endcase
    trials = cfg_q.res10 ? CNT_W'(RES_W) : CNT_W'(BYTE_W);
    samp   = len - trials;
  end

  assign in_trial = active && (cnt_q >= samp);
  assign bit_idx  = BIT_W'(CNT_W'(RES_W - 1) + samp - cnt_q);
  assign commit   = active && tick && (cnt_q == len - CNT_W'(1));

  always_comb begin
    unique case (cfg_q.mode)
      SCAN_REPEAT: cont = run && !start_clr;
      SCAN_SWEEP:  cont = run && !start_clr && (cur_chan != last_q);
      default:     cont = 1'b0;
    endcase
  end

  assign acc_clear = go || (commit && cont);
  assign cfg_res10 = cfg_q.res10;
  assign cfg_div   = cfg_q.div;
  assign cfg_mode  = cfg_q.mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q    <= '{res10: 1'b0, sh: 1'b0, div: 2'd0, mode: SCAN_SINGLE};
      last_q   <= '0;
      cur_chan <= '0;
      cnt_q    <= '0;
      run      <= 1'b0;
      active   <= 1'b0;
    end else if (go) begin
      cfg_q    <= '{res10: res10_in, sh: sh_in, div: div_in,
                    mode: scan_mode_e'(mode_in)};
      last_q   <= chan_in;
      cur_chan <= (scan_mode_e'(mode_in) == SCAN_SWEEP) ? '0 : chan_in;
      cnt_q    <= '0;
      run      <= 1'b1;
      active   <= 1'b1;
    end else begin
      if (start_clr) run <= 1'b0;
      if (commit) begin
        cnt_q <= '0;
        if (cont) begin
          if (cfg_q.mode == SCAN_SWEEP) cur_chan <= cur_chan + CH_W'(1);
        end else begin
          active <= 1'b0;
          run    <= 1'b0;
        end
      end else if (active && tick) begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/sar_trial.sv
module sar_trial #(
  parameter int RES_W = 10,
  parameter int BIT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             tick,
  input  logic             in_trial,
  input  logic [BIT_W-1:0] bit_idx,
  input  logic             cmp_in,
  output logic [RES_W-1:0] dac_code,
  output logic [RES_W-1:0] res_now
);
  logic [RES_W-1:0] acc_q;
  logic [RES_W-1:0] mask;

  always_comb begin
    mask = '0;
    if (in_trial) mask[bit_idx] = 1'b1;
    dac_code = in_trial ? (acc_q | mask) : '0;
    res_now  = acc_q;
    if (in_trial && tick) res_now[bit_idx] = cmp_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 acc_q <= '0;
    else if (clear)             acc_q <= '0;
    else if (in_trial && tick)  acc_q <= res_now;
  end
endmodule

// File: rtl/sar_resbank.sv
module sar_resbank
  import sar_pkg::*;
#(
  parameter int NUM_CH = 13,
  parameter int RES_W  = 10,
  parameter int CH_W   = 4,
  parameter int AW     = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CH_W-1:0]   wr_chan,
  input  logic              wr_res10,
  input  logic [RES_W-1:0]  wr_val,
  input  logic [AW-1:0]     rd_addr,
  output logic [BYTE_W-1:0] rd_data
);
  localparam int HI_W = RES_W - BYTE_W;

  logic [NUM_CH-1:0][BYTE_W-1:0] lo_all;
  logic [NUM_CH-1:0][HI_W-1:0]   hi_all;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic [BYTE_W-1:0] lo_q;
    logic [HI_W-1:0]   hi_q;
    logic              hit;
    assign hit = wr_en && (wr_chan == CH_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lo_q <= '0;
        hi_q <= '0;
      end else if (hit) begin
        lo_q <= wr_res10 ? wr_val[BYTE_W-1:0] : wr_val[RES_W-1 -: BYTE_W];
        if (wr_res10) hi_q <= wr_val[RES_W-1:BYTE_W];
      end
    end
    assign lo_all[g] = lo_q;
    assign hi_all[g] = hi_q;
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (rd_addr[AW-1:1] == CH_W'(i))
        rd_data = rd_addr[0] ? {{(BYTE_W-HI_W){1'b0}}, hi_all[i]} : lo_all[i];
    end
  end
endmodule

// File: rtl/sar_conv_seq.sv
module sar_conv_seq
  import sar_pkg::*;
#(
  parameter int NUM_CH       = 13,
  parameter int RES_W        = 10,
  parameter int LEN_PLAIN_LO = 49,
  parameter int LEN_PLAIN_HI = 59,
  parameter int LEN_SH_LO    = 28,
  parameter int LEN_SH_HI    = 33,
  localparam int CH_W        = $clog2(NUM_CH),
  localparam int AW          = CH_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_on,
  input  logic              start_set,
  input  logic              start_clr,
  input  logic              res10_sel,
  input  logic              sh_en,
  input  logic [1:0]        div_sel,
  input  logic [1:0]        mode_sel,
  input  logic [CH_W-1:0]   chan_sel,
  input  logic              cmp_in,
  output logic [RES_W-1:0]  dac_code,
  output logic [CH_W-1:0]   conv_chan,
  output logic              busy,
  output logic              start_flag,
  output logic              res_valid,
  output logic [CH_W-1:0]   res_chan,
  output logic [RES_W-1:0]  res_data,
  input  logic [AW-1:0]     rd_addr,
  output logic [BYTE_W-1:0] rd_data
);
  localparam int LEN_A   = (LEN_PLAIN_LO > LEN_PLAIN_HI) ? LEN_PLAIN_LO : LEN_PLAIN_HI;
  localparam int LEN_B   = (LEN_SH_LO > LEN_SH_HI) ? LEN_SH_LO : LEN_SH_HI;
  localparam int LEN_MAX = (LEN_A > LEN_B) ? LEN_A : LEN_B;
  localparam int CNT_W   = $clog2(LEN_MAX + 1);
  localparam int BIT_W   = $clog2(RES_W);

  logic             go, active, run, tick, cfg_res10, in_trial, acc_clear, commit;
  logic [1:0]       cfg_div, cfg_mode;
  logic [BIT_W-1:0] bit_idx;
  logic [RES_W-1:0] res_now, res_fmt;

  sar_ctrl #(
    .NUM_CH(NUM_CH), .RES_W(RES_W),
    .LEN_PLAIN_LO(LEN_PLAIN_LO), .LEN_PLAIN_HI(LEN_PLAIN_HI),
    .LEN_SH_LO(LEN_SH_LO), .LEN_SH_HI(LEN_SH_HI),
    .CH_W(CH_W), .CNT_W(CNT_W), .BIT_W(BIT_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .ref_on(ref_on),
    .start_set(start_set), .start_clr(start_clr),
    .res10_in(res10_sel), .sh_in(sh_en), .div_in(div_sel),
    .mode_in(mode_sel), .chan_in(chan_sel), .tick(tick),
    .go(go), .active(active), .run(run),
    .cfg_res10(cfg_res10), .cfg_div(cfg_div), .cfg_mode(cfg_mode),
    .cur_chan(conv_chan), .in_trial(in_trial), .bit_idx(bit_idx),
    .acc_clear(acc_clear), .commit(commit)
  );

  sar_prescale u_div (
    .clk(clk), .rst_n(rst_n), .restart(go), .active(active),
    .div_sel(cfg_div), .tick(tick)
  );

  sar_trial #(.RES_W(RES_W), .BIT_W(BIT_W)) u_trial (
    .clk(clk), .rst_n(rst_n), .clear(acc_clear), .tick(tick),
    .in_trial(in_trial), .bit_idx(bit_idx), .cmp_in(cmp_in),
    .dac_code(dac_code), .res_now(res_now)
  );

  sar_resbank #(.NUM_CH(NUM_CH), .RES_W(RES_W), .CH_W(CH_W), .AW(AW)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(commit), .wr_chan(conv_chan),
    .wr_res10(cfg_res10), .wr_val(res_now),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  assign res_fmt    = cfg_res10 ? res_now
                                : {{(RES_W-BYTE_W){1'b0}}, res_now[RES_W-1 -: BYTE_W]};
  assign busy       = active;
  assign start_flag = run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_chan  <= '0;
      res_data  <= '0;
    end else begin
      res_valid <= commit;
      if (commit) begin
        res_chan <= conv_chan;
        res_data <= res_fmt;
      end
    end
  end
endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
  parameter int RES_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ref_on,
  input logic             busy,
  input logic             start_flag,
  input logic [RES_W-1:0] dac_code,
  input logic             res_valid,
  input logic [RES_W-1:0] res_data,
  input logic             cfg_res10,
  input logic [1:0]       cfg_mode
);
  AST_DAC_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> dac_code == '0); // R3

  AST_REF_GATES_START: assert property (@(posedge clk) disable iff (!rst_n)
    (!ref_on && !busy && !start_flag) |=> !busy); // R6

  AST_BUSY_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> start_flag); // R6

  AST_LOW_RES_LSB_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !cfg_res10) |-> dac_code[RES_W-9:0] == '0); // R4

  AST_SINGLE_CLEARS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && cfg_mode == 2'd0) |-> !start_flag); // R7

  AST_STROBE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(busy)); // R10

  AST_LOW_RES_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !cfg_res10) |-> res_data[RES_W-1:8] == '0); // R4
endmodule

bind sar_conv_seq sar_seq_chk #(.RES_W(RES_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ref_on(ref_on), .busy(busy),
  .start_flag(start_flag), .dac_code(dac_code), .res_valid(res_valid),
  .res_data(res_data), .cfg_res10(cfg_res10), .cfg_mode(cfg_mode)
);

// File: tb/test_sar_conv_seq.sv
`timescale 1ns/1ps
module test_sar_conv_seq;
  localparam int NUM_CH = 13;
  localparam int RES_W  = 10;
  localparam int CH_W   = 4;
  localparam int AW     = 5;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, ref_on, start_set, start_clr, res10_sel, sh_en, cmp_in;
  logic [1:0] div_sel, mode_sel;
  logic [CH_W-1:0] chan_sel, conv_chan, res_chan;
  logic [RES_W-1:0] dac_code, res_data;
  logic busy, start_flag, res_valid;
  logic [AW-1:0] rd_addr;
  logic [7:0] rd_data;

  logic [RES_W-1:0] ana [NUM_CH];
  assign cmp_in = (ana[conv_chan] >= dac_code);

  sar_conv_seq i_sar_conv_seq (
    .clk(clk), .rst_n(rst_n), .ref_on(ref_on), .start_set(start_set),
    .start_clr(start_clr), .res10_sel(res10_sel), .sh_en(sh_en),
    .div_sel(div_sel), .mode_sel(mode_sel), .chan_sel(chan_sel),
    .cmp_in(cmp_in), .dac_code(dac_code), .conv_chan(conv_chan),
    .busy(busy), .start_flag(start_flag), .res_valid(res_valid),
    .res_chan(res_chan), .res_data(res_data), .rd_addr(rd_addr),
    .rd_data(rd_data)
  );

  int n_vec = 0, n_bad = 0;
  int sb_vec = 0, sb_bad = 0, n_res = 0;
  int run_busy = 0, run_trials = 0, run_first_at = 0;
  logic [RES_W-1:0] run_first_code = '0;
  logic prev_busy = 1'b0;
  logic [CH_W+RES_W-1:0] exp_q [$];

  // Scoreboard monitor: per-run busy/trial statistics and result comparison
  always @(negedge clk) begin
    if (busy && !prev_busy) begin
      run_busy = 1; run_trials = 0; run_first_at = 0; run_first_code = '0;
    end else if (busy) begin
      run_busy++;
    end
    if (busy && dac_code != '0) begin
      if (run_trials == 0) begin
        run_first_at = run_busy; run_first_code = dac_code;
      end
      run_trials++;
    end
    prev_busy = busy;
    if (res_valid) begin
      n_res++;
      sb_vec++;
      if (exp_q.size() == 0) begin
        sb_bad++;
        $display("FAIL R10 unexpected result act=%0h/%0h exp=none", res_chan, res_data);
      end else begin
        logic [CH_W+RES_W-1:0] e;
        e = exp_q.pop_front();
        if ({res_chan, res_data} !== e) begin
          sb_bad++;
          $display("FAIL R10 result act=%0h/%0h exp=%0h/%0h",
                   res_chan, res_data, e[CH_W+RES_W-1:RES_W], e[RES_W-1:0]);
        end
      end
    end
  end

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic expect_res(input int ch, input logic r10, input logic [RES_W-1:0] v);
    logic [RES_W-1:0] d;
    d = r10 ? v : {2'b00, v[RES_W-1:2]};
    exp_q.push_back({CH_W'(ch), d});
  endtask

  task automatic kick(input logic [1:0] md, input int ch, input logic r10,
                      input logic sh, input logic [1:0] dv);
    mode_sel = md; chan_sel = CH_W'(ch); res10_sel = r10; sh_en = sh; div_sel = dv;
    start_set = 1'b1;
    step();
    start_set = 1'b0;
  endtask

  task automatic wait_idle(input string tag);
    int k = 0;
    while ((busy || start_flag) && k < 2000) begin step(); k++; end
    if (k >= 2000) chk({tag, " timeout"}, 32'd1, 32'd0);
    step();
  endtask

  task automatic rd(input string tag, input int addr, input logic [7:0] exp);
    rd_addr = AW'(addr);
    #1;
    chk(tag, {24'd0, rd_data}, {24'd0, exp});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog act=running exp=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec + sb_vec + 1, n_bad + sb_bad + 1);
    $finish;
  end

  initial begin
    int r0;
    rst_n = 1'b0; ref_on = 1'b1; start_set = 1'b0; start_clr = 1'b0;
    res10_sel = 1'b1; sh_en = 1'b0; div_sel = 2'd0; mode_sel = 2'd0;
    chan_sel = '0; rd_addr = '0;
    for (int i = 0; i < NUM_CH; i++) ana[i] = RES_W'(i * 37);
    repeat (3) step();
    rst_n = 1'b1;
    step();

    // Reset state
    chk("R5 reset busy", {31'd0, busy}, 32'd0);
    chk("R7 reset flag", {31'd0, start_flag}, 32'd0);
    chk("R3 reset dac", {22'd0, dac_code}, 32'd0);
    rd("R5 reset byte", 7, 8'h00);

    // Single, 10-bit, no S&H, divide by 1
    ana[3] = 10'h2A5;
    expect_res(3, 1'b1, ana[3]);
    kick(2'd0, 3, 1'b1, 1'b0, 2'd0);
    wait_idle("R7 single");
    chk("R2 busy 59", run_busy, 59);
    chk("R3 trial count", run_trials, 10);
    chk("R3 first trial MSB", {22'd0, run_first_code}, 32'h200);
    chk("R3 sampling phase 49", run_first_at, 50);
    chk("R7 flag cleared", {31'd0, start_flag}, 32'd0);
    rd("R5 low byte", 6, 8'hA5);
    rd("R5 high byte", 7, 8'h02);

    // Single, 10-bit, S&H, divide by 2, top channel
    ana[12] = 10'h3FF;
    expect_res(12, 1'b1, ana[12]);
    kick(2'd0, 12, 1'b1, 1'b1, 2'd1);
    wait_idle("R1 div2");
    chk("R1 R2 busy 33x2", run_busy, 66);
    rd("R5 ch12 low", 24, 8'hFF);
    rd("R5 ch12 high", 25, 8'h03);

    // Single, 8-bit, no S&H, divide by 4; odd byte must keep old value
    ana[3] = 10'h155;
    expect_res(3, 1'b0, ana[3]);
    kick(2'd0, 3, 1'b0, 1'b0, 2'd2);
    wait_idle("R4 8bit");
    chk("R1 R2 busy 49x4", run_busy, 196);
    chk("R4 trial cycles", run_trials, 32);
    chk("R3 sampling 41x4", run_first_at, 165);
    rd("R4 even byte", 6, 8'h55);
    rd("R4 odd byte kept", 7, 8'h02);

    // Single, 8-bit, S&H, divide-select 3 (acts as 4) -> 28x4
    ana[0] = 10'h0F3;
    expect_res(0, 1'b0, ana[0]);
    kick(2'd3, 0, 1'b0, 1'b1, 2'd3);
    wait_idle("R1 div3");
    chk("R1 R2 busy 28x4", run_busy, 112);
    rd("R4 ch0 even", 0, 8'h3C);

    // Start ignored without reference, and for an invalid channel
    r0 = n_res;
    ref_on = 1'b0;
    kick(2'd0, 1, 1'b1, 1'b0, 2'd0);
    repeat (8) step();
    chk("R6 no ref busy", {31'd0, busy}, 32'd0);
    chk("R6 no ref flag", {31'd0, start_flag}, 32'd0);
    ref_on = 1'b1;
    kick(2'd0, 13, 1'b1, 1'b0, 2'd0);
    repeat (8) step();
    chk("R6 bad chan busy", {31'd0, busy}, 32'd0);
    chk("R6 no results", n_res - r0, 0);

    // Sweep 0..4, 10-bit, S&H, divide by 1
    ana[0] = 10'h0F0; ana[1] = 10'h301; ana[2] = 10'h1C3; ana[3] = 10'h155; ana[4] = 10'h3A7;
    for (int c = 0; c <= 4; c++) expect_res(c, 1'b1, ana[c]);
    r0 = n_res;
    kick(2'd2, 4, 1'b1, 1'b1, 2'd0);
    wait_idle("R9 sweep");
    chk("R9 sweep busy 5x33", run_busy, 165);
    chk("R9 sweep results", n_res - r0, 5);
    chk("R9 flag cleared", {31'd0, start_flag}, 32'd0);
    rd("R9 ch4 low", 8, 8'hA7);
    rd("R9 ch1 high", 3, 8'h03);

    // Repeat on channel 5; clear during the third conversion
    ana[5] = 10'h2C9;
    for (int c = 0; c < 3; c++) expect_res(5, 1'b1, ana[5]);
    r0 = n_res;
    kick(2'd1, 5, 1'b1, 1'b1, 2'd0);
    repeat (70) step();
    chk("R8 still running", {31'd0, busy}, 32'd1);
    start_clr = 1'b1;
    step();
    start_clr = 1'b0;
    chk("R8 flag cleared", {31'd0, start_flag}, 32'd0);
    chk("R8 finishes current", {31'd0, busy}, 32'd1);
    wait_idle("R8 repeat");
    chk("R8 busy 3x33", run_busy, 99);
    chk("R8 three results", n_res - r0, 3);

    // Configuration captured at start
    ana[2] = 10'h1C3;
    expect_res(2, 1'b1, ana[2]);
    kick(2'd0, 2, 1'b1, 1'b0, 2'd0);
    repeat (5) step();
    res10_sel = 1'b0; chan_sel = 4'd7; sh_en = 1'b1; div_sel = 2'd2; mode_sel = 2'd1;
    wait_idle("R11 latch");
    chk("R11 busy unchanged", run_busy, 59);
    rd("R11 ch2 low", 4, 8'hC3);
    rd("R11 ch2 high", 5, 8'h01);
    rd("R11 ch7 untouched", 14, 8'((7 * 37) & 8'hFF) & 8'h00);

    // Unmapped addresses
    rd("R5 addr 26", 26, 8'h00);
    rd("R5 addr 31", 31, 8'h00);

    repeat (3) step();
    chk("R10 queue drained", exp_q.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec + sb_vec, n_bad + sb_bad);
    $finish;
  end
endmodule